// File: doc/BRIEF.md
# Two-Wire Bus Serial Clock Prescaler

This block derives the serial-clock timing of a two-wire bus master from a fast system clock. Software sets the bus rate by writing one byte through a narrow register write port. The byte carries two fields: a power-of-two exponent and a linear multiplier. Two counters are chained. The first divides the system clock by 2^(N+1). The second divides that result by (M+1). The output is a one-cycle `phase_tick` every P = (M+1)·2^(N+1) system clocks.

A phase counter groups ten ticks into one serial-clock period. It drives `scl_hi`, which is high for the first five ticks of each group and low for the last five. The bus therefore runs at f_sys / (10·(M+1)·2^(N+1)). The bit-level engine uses `phase_tick` to place its edges and `scl_hi` to know which half of the period it is in.

Each of the following clears every counter, so the new timing begins from a clean phase:
- a write to the rate register,
- a write to the soft-reset location,
- dropping the controller enable.

Top module: `scl_prescaler`

## Requirements
- R1: A write to offset 0x0C loads the rate register. N is taken from data bits [2:0] and M from data bits [6:3]. Bit 7 has no effect on the rate.
- R2: While enabled, `phase_tick` is high for exactly one cycle every P = (M+1)·2^(N+1) system clocks, for every M in 0..15 and N in 0..7.
- R3: Ticks are numbered from 0 starting at the last restart. In the cycle of tick k, `scl_hi` is 1 when k mod 10 is below 5 and 0 otherwise, so one serial-clock period spans ten ticks.
- R4: A write to offset 0x0C restarts the dividers and the phase. The first tick after the write comes exactly P cycles after the cycle in which the write was presented, using the new P, and it is tick number 0.
- R5: A write to offset 0x1C sets M and N to zero (P = 2) and restarts the dividers and the phase in the same way as R4.
- R6: While `ctrl_en` is 0, `phase_tick` and `scl_hi` are 0 and all counters hold at zero. The first tick comes P cycles after the last cycle in which `ctrl_en` was 0, and it is tick number 0.
- R7: Writes to any other offset change neither the rate nor the phase. The tick stream continues undisturbed.
- R8: Synchronous active-low reset sets M and N to zero and clears all counters. With `ctrl_en` low during reset, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; low holds the divider at zero |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | ADDR_W (5) | Byte offset of the write |
| wr_data | input | 8 | Write data byte |
| phase_tick | output | 1 | One-cycle pulse every (M+1)·2^(N+1) clocks |
| scl_hi | output | 1 | High during the first half of each ten-tick serial-clock period |

## Verification
The assertions assume three things about the inputs:
- Reset lasts at least one clock edge.
- `wr_en` is a single-cycle strobe.
- A rate change reaches the register only through a write that also clears the counters. The range checks on the counters rely on this.

The stimulus follows these rules. It drives every input one time unit after a rising edge. It raises `wr_en` for exactly one cycle per write. It holds `ctrl_en` low through reset. Some writes are placed in the middle of a divider period, to show that the restart does not depend on the phase at which the write arrives.

// File: rtl/scl_div_pkg.sv
// Package: shared definitions for the serial-clock prescaler.
// Holds the decoded write classification used between the register
// slice and the divider chain.
package scl_div_pkg;

    // Kind of register write seen on the write port this cycle
    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_RATE  = 2'd1,
        WR_SRST  = 2'd2,
        WR_OTHER = 2'd3
    } wr_kind_e;

    // Default byte offsets of the two locations the block decodes
    localparam logic [4:0] RATE_OFS_DEF = 5'h0C;
    localparam logic [4:0] SRST_OFS_DEF = 5'h1C;

endpackage

// File: rtl/scl_rate_reg.sv
// Module: scl_rate_reg
// Decodes writes on the byte-wide register port and keeps the M/N rate
// fields. A write to RATE_OFS loads N from the low bits and M from the
// bits above them. A write to SRST_OFS returns both fields to zero.
// Either write raises 'restart' in the same cycle, so the divider clears
// on the same edge that the new rate lands.
// Assumes: N_W + M_W <= 8; wr_en is a one-cycle strobe.
module scl_rate_reg
    import scl_div_pkg::*;
#(
    parameter int         ADDR_W   = 5,
    parameter int         M_W      = 4,
    parameter int         N_W      = 3,
    parameter logic [4:0] RATE_OFS = RATE_OFS_DEF,
    parameter logic [4:0] SRST_OFS = SRST_OFS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic [M_W-1:0]    m_q,
    output logic [N_W-1:0]    n_q,
    output logic              restart
);

    localparam int FIELD_W = M_W + N_W;

    wr_kind_e wr_kind;

    // Classify the current write by its offset
    always_comb begin
        if (!wr_en)
            wr_kind = WR_NONE;
        else if (wr_addr == ADDR_W'(RATE_OFS))
            wr_kind = WR_RATE;
        else if (wr_addr == ADDR_W'(SRST_OFS))
            wr_kind = WR_SRST;
        else
            wr_kind = WR_OTHER;
    end

    assign restart = (wr_kind == WR_RATE) || (wr_kind == WR_SRST);

    // Hold the rate fields; load on a rate write, zero on soft reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
            n_q <= '0;
        end else if (wr_kind == WR_RATE) begin
            n_q <= wr_data[N_W-1:0];
            m_q <= wr_data[FIELD_W-1:N_W];
        end else if (wr_kind == WR_SRST) begin
            m_q <= '0;
            n_q <= '0;
        end
    end

    // Data bits above the fields carry no meaning for the rate
    generate
        if (FIELD_W < 8) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^wr_data[7:FIELD_W];
        end
    endgenerate

    // R5: soft reset leaves both fields at zero
    p_srst_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(SRST_OFS)) |=> (m_q == '0 && n_q == '0));

    // R7: writes elsewhere leave the fields untouched
    p_other_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != ADDR_W'(RATE_OFS) && wr_addr != ADDR_W'(SRST_OFS))
        |=> ($stable(m_q) && $stable(n_q)));

    // R1: a rate write lands both fields on the next edge
    p_rate_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(RATE_OFS))
        |=> (n_q == $past(wr_data[N_W-1:0]) && m_q == $past(wr_data[FIELD_W-1:N_W])));

endmodule

// File: rtl/scl_pow2_div.sv
// Module: scl_pow2_div
// First divider stage: counts system clocks modulo 2^(N+1) and pulses
// 'stage_tick' on the last count. 'clr' forces the count to zero, and
// the count restarts from zero after a clear.
// Assumes: n_sel only changes on a cycle where clr is also high.
module scl_pow2_div #(
    parameter int N_W   = 3,
    parameter int CNT_W = (1 << N_W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           run,
    input  logic [N_W-1:0] n_sel,
    output logic           stage_tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;

    // Terminal count 2^(N+1)-1 for the selected exponent
    assign last_cnt = CNT_W'((32'd2 << n_sel) - 32'd1);

    assign stage_tick = run && (cnt_q == last_cnt);

    // Advance the power-of-two count, wrapping at the terminal value
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (cnt_q == last_cnt)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: the count never passes the terminal value
    p_pow_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last_cnt);

    // R4: a clear leaves the count at zero
    p_pow_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/scl_lin_div.sv
// Module: scl_lin_div
// Second divider stage: counts first-stage pulses modulo (M+1). On the
// pulse that completes a group it raises 'tick', the block-level phase
// tick. 'clr' returns the count to zero.
// Assumes: m_sel only changes on a cycle where clr is also high.
module scl_lin_div #(
    parameter int M_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           stage_in,
    input  logic [M_W-1:0] m_sel,
    output logic           tick
);

    logic [M_W-1:0] cnt_q;

    assign tick = stage_in && (cnt_q == m_sel);

    // Count first-stage pulses, wrapping after M+1 of them
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt_q <= '0;
        else if (stage_in) begin
            if (cnt_q == m_sel)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2: the count never passes M
    p_lin_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= m_sel);

    // R2: a phase tick can only come from a first-stage pulse
    p_tick_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> stage_in);

    // R4: the count holds between first-stage pulses
    p_lin_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stage_in && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/scl_phase_gen.sv
// Module: scl_phase_gen
// Groups phase ticks into serial-clock periods of PHASES ticks. 'scl_hi'
// is high while the phase index is in the first half of the period, and
// only while enabled.
// Assumes: PHASES is even and at least 2.
module scl_phase_gen #(
    parameter int PHASES = 10,
    parameter int PH_W   = $clog2(PHASES)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic tick,
    output logic scl_hi
);

    localparam int HALF = PHASES / 2;

    logic [PH_W-1:0] ph_q;

    assign scl_hi = en && (ph_q < PH_W'(HALF));

    // Step the phase index on every tick, wrapping after the last phase
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            ph_q <= '0;
        else if (tick) begin
            if (ph_q == PH_W'(PHASES - 1))
                ph_q <= '0;
            else
                ph_q <= ph_q + 1'b1;
        end
    end

    // R3: phase index stays inside one period
    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q < PH_W'(PHASES));

    // R3: the last phase wraps to the first on a tick
    p_phase_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr && ph_q == PH_W'(PHASES - 1)) |=> (ph_q == '0));

    // R6: the serial clock is never high while disabled
    p_scl_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hi |-> en);

    // R6: tick never arrives while disabled
    p_tick_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> en);

endmodule

// File: rtl/scl_prescaler.sv
// Module: scl_prescaler (top)
// Serial-clock prescaler for a two-wire bus master. The rate register
// feeds a power-of-two stage followed by a linear stage. Together they
// give one phase tick every (M+1)*2^(N+1) clocks, and ten ticks make one
// serial-clock period. A rate write, a soft-reset write or a low enable
// clears every counter.
// Assumes: synchronous active-low reset; wr_en is a one-cycle strobe.
module scl_prescaler
    import scl_div_pkg::*;
#(
    parameter int         ADDR_W   = 5,
    parameter int         M_W      = 4,
    parameter int         N_W      = 3,
    parameter int         PHASES   = 10,
    parameter logic [4:0] RATE_OFS = RATE_OFS_DEF,
    parameter logic [4:0] SRST_OFS = SRST_OFS_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              phase_tick,
    output logic              scl_hi
);

    localparam int POW_W = (1 << N_W);

    logic [M_W-1:0] m_q;
    logic [N_W-1:0] n_q;
    logic           restart;
    logic           clr;
    logic           pow_tick;

    // Counters clear on a restart write or while disabled
    assign clr = restart || !ctrl_en;

    scl_rate_reg #(
        .ADDR_W  (ADDR_W),
        .M_W     (M_W),
        .N_W     (N_W),
        .RATE_OFS(RATE_OFS),
        .SRST_OFS(SRST_OFS)
    ) u_rate (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .m_q    (m_q),
        .n_q    (n_q),
        .restart(restart)
    );

    scl_pow2_div #(
        .N_W  (N_W),
        .CNT_W(POW_W)
    ) u_pow2 (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .run       (ctrl_en),
        .n_sel     (n_q),
        .stage_tick(pow_tick)
    );

    scl_lin_div #(
        .M_W(M_W)
    ) u_lin (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .stage_in(pow_tick),
        .m_sel   (m_q),
        .tick    (phase_tick)
    );

    scl_phase_gen #(
        .PHASES(PHASES)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .en    (ctrl_en),
        .tick  (phase_tick),
        .scl_hi(scl_hi)
    );

    // R6: a disabled block emits no tick and no serial-clock high
    p_quiet_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> (!phase_tick && !scl_hi));

    // R4: the cycle after a restart never carries a tick (P is at least 2)
    p_no_tick_after_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !phase_tick);

endmodule

// File: tb/scl_prescaler_tb.sv
// Scoreboard bench for scl_prescaler. Driver tasks queue the expected
// gap and serial-clock level for each coming tick. A monitor pops one
// entry per observed tick and compares.
module scl_prescaler_tb;

    localparam logic [4:0] A_RATE = 5'h0C;
    localparam logic [4:0] A_SRST = 5'h1C;

    typedef struct {
        int    gap;
        bit    hi;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       phase_tick;
    logic       scl_hi;

    int   cyc = 0;
    int   last_ev = 0;
    int   idx = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sbq[$];

    scl_prescaler u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_en   (ctrl_en),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .phase_tick(phase_tick),
        .scl_hi    (scl_hi)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop one expectation per tick and compare gap and level
    always @(negedge clk) begin
        if (rst_n && phase_tick) begin
            if (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                checks++;
                if ((cyc - last_ev) != e.gap || scl_hi != e.hi) begin
                    errors++;
                    $display("FAIL %s: gap %0d scl %0b, expected gap %0d scl %0b",
                             e.req, cyc - last_ev, scl_hi, e.gap, e.hi);
                end
            end
            last_ev = cyc;
            idx++;
        end
    end

    // Watchdog: a hung run counts as one failed check
    always @(posedge clk) begin
        if (!done && cyc > 180000) begin
            errors++;
            $display("FAIL watchdog: cycle %0d, expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Queue the next 'num' ticks, numbered from the current tick index
    task automatic expect_ticks(input int num, input int gap, input string req);
        for (int j = 0; j < num; j++) begin
            exp_t e;
            e.gap = gap;
            e.hi  = ((idx + j) % 10) < 5;
            e.req = req;
            sbq.push_back(e);
        end
    endtask

    task automatic drain();
        while (sbq.size() > 0) @(posedge clk);
        #1;
    endtask

    // One-cycle write; returns the cycle in which it was presented
    task automatic do_write(input logic [4:0] a, input logic [7:0] d, output int wcyc);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        wcyc = cyc;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Rate or soft-reset write that restarts numbering
    task automatic restart_write(input logic [4:0] a, input logic [7:0] d);
        int w;
        do_write(a, d, w);
        last_ev = w;
        idx = 0;
    endtask

    task automatic check_level(input bit got, input bit exp, input string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b, expected %0b", req, got, exp);
        end
    endtask

    initial begin
        int w;
        // R8: outputs quiet during reset with the enable low
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_level(phase_tick, 1'b0, "R8 tick in reset");
        check_level(scl_hi, 1'b0, "R8 scl in reset");
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R8 R6: after reset the rate is P=2; enable starts a fresh phase
        repeat (4) @(posedge clk); #1;
        ctrl_en = 1'b1;
        last_ev = cyc - 1;
        idx = 0;
        expect_ticks(12, 2, "R8 reset rate");
        drain();

        // R1 R2 R4: explicit M=0,N=0
        restart_write(A_RATE, 8'h00);
        expect_ticks(12, 2, "R2 M0N0");
        drain();

        // R1 R2: M=3,N=2 -> P=4*8=32
        restart_write(A_RATE, 8'h1A);
        expect_ticks(12, 32, "R2 M3N2");
        drain();

        // R4: rewrite in the middle of a period, same value
        repeat (13) @(posedge clk);
        restart_write(A_RATE, 8'h1A);
        expect_ticks(12, 32, "R4 mid restart");
        drain();

        // R1 R2: M=7,N=4 -> P=8*32=256
        restart_write(A_RATE, 8'h3C);
        expect_ticks(12, 256, "R2 M7N4");
        drain();

        // R1: bit 7 ignored; M=1,N=1 -> P=8
        restart_write(A_RATE, 8'h89);
        expect_ticks(12, 8, "R1 bit7");
        drain();

        // R7: writes to other offsets leave rate and phase alone
        expect_ticks(14, 8, "R7 other offset");
        repeat (19) @(posedge clk);
        do_write(5'h04, 8'h7F, w);
        repeat (5) @(posedge clk);
        do_write(5'h10, 8'h00, w);
        drain();

        // R6: disable holds everything quiet, then restarts cleanly
        @(posedge clk); #1;
        ctrl_en = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check_level(phase_tick | scl_hi, 1'b0, "R6 disabled outputs");
        end
        @(posedge clk); #1;
        ctrl_en = 1'b1;
        last_ev = cyc - 1;
        idx = 0;
        expect_ticks(12, 8, "R6 re-enable");
        drain();

        // R2: largest divider M=15,N=7 -> P=16*256=4096
        restart_write(A_RATE, 8'h7F);
        expect_ticks(11, 4096, "R2 M15N7");
        drain();

        // R5: soft reset returns to P=2 with a clean phase
        repeat (300) @(posedge clk);
        restart_write(A_SRST, 8'hFF);
        expect_ticks(12, 2, "R5 soft reset");
        drain();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule